// File: doc/BRIEF.md
# Embedded-Clock Word Deserializer with Lock Detection

This block rebuilds 10-bit words from a one-bit-per-strobe serial stream. On the line, every payload is wrapped in a 12-bit slot. A clock bit fixed at 1 opens the slot, ten payload bits follow with the least significant bit first, and a clock bit fixed at 0 closes it. The block samples `bit_in` on each `clk` edge where `bit_vld` is high and ignores every other cycle. It looks for a slot boundary and holds that alignment for a qualification run of `QUAL_WORDS` framed slots before it reports lock. While locked, it delivers each payload with a one-cycle strobe and a recovered word clock.

The controller is a four-state machine:
- **OFF**: power-down.
- **SEARCH**: hunts for a window with a 1 at its oldest bit and a 0 at its newest.
- **QUALIFY**: counts consecutive framed slots from the detection onward.
- **LOCKED**: delivers words.

The transitions are:
- OFF to SEARCH when power returns.
- SEARCH to QUALIFY on a candidate window.
- QUALIFY to SEARCH on any unframed slot.
- QUALIFY to LOCKED on the last qualifying slot.
- LOCKED to SEARCH on a second unframed slot in a row.
- Any state to OFF while `pwr_on` is low.

The active-low `lock_n` flag shows when words are valid. A single output-drive enable, `drv_en`, stands in for the tri-state pads on the data, strobe and clock outputs. A `suspect` flag marks the first word after a relock that follows a loss of lock.

Top module: `ecframe_deser`

## Requirements
- R1: A slot is, in order: a 1, payload bits p0..p9 (p0 is `word_out[0]`), then a 0. A delivered word equals the payload of the slot whose closing bit was just taken in.
- R2: Lock needs `QUAL_WORDS` (default 80) consecutive framed slots, counting the slot that first matched. `lock_n` falls, with `word_stb` high and that last slot's payload on `word_out`, in the cycle after its closing bit is taken in. After `QUAL_WORDS`-1 slots, `lock_n` is still high.
- R3: An unframed slot (opening bit not 1 or closing bit not 0) during qualification returns the block to SEARCH, and no lock follows from that run.
- R4: A single unframed slot while locked keeps `lock_n` low, gives no `word_stb`, and leaves `word_out` unchanged. The next framed slot delivers normally.
- R5: Two consecutive unframed slots while locked raise `lock_n` and drop `drv_en`. The block then searches and relocks on its own, with no control input.
- R6: While `lock_n` is high, `drv_en`, `word_stb`, `rclk` and `suspect` are all 0.
- R7: While `pwr_on` is low, `lock_n` is 1 and `drv_en` is 0 in the same cycle, and all state is cleared. After power returns, a full qualification is needed again.
- R8: While `out_en` is low, `drv_en`, `word_stb` and `rclk` are 0 and `lock_n` is unaffected. When `out_en` returns high, the next framed slot is delivered without relocking.
- R9: In the cycle a word is delivered, `rclk` is 1 when `fall_sel`=0 (rising edge) and 0 when `fall_sel`=1 (falling edge). It keeps that level for 6 bit strobes, then inverts for the remaining 6.
- R10: `suspect` is 1 on the first word delivered after a relock that followed a loss of lock, and is cleared by the next word. The first lock after reset or power-up is not suspect.
- R11: Cycles with `bit_vld` low take in no bit and do not advance the slot position.
- R12: After reset, `lock_n`=1 and `drv_en`, `word_stb`, `rclk`, `suspect` and `word_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_on | input | 1 | Low selects power-down |
| out_en | input | 1 | Output drive enable request |
| fall_sel | input | 1 | 1 aligns words to the falling edge of `rclk` |
| bit_vld | input | 1 | Qualifies `bit_in` this cycle |
| bit_in | input | 1 | Serial line bit |
| word_out | output | WORD_W | Recovered payload, 0 when not driven |
| word_stb | output | 1 | One-cycle strobe for a new word |
| drv_en | output | 1 | Outputs are driven (models pad enable) |
| rclk | output | 1 | Recovered word clock |
| lock_n | output | 1 | Low while locked |
| suspect | output | 1 | First word after a relock may be corrupt |

## Verification
A wrong slot phase shows up at the ports within one slot, because delivered words come out shifted by one or more bit positions. A wrong qualification count moves the falling edge of `lock_n` by at least one slot, about 12 bit strobes, away from slot 80. A wrong miss count shows up at the first unframed slot: either `lock_n` rises after a single miss, or it fails to rise after two. A stale loss-history bit is visible only on the first word after the next relock, through `suspect`.

// File: rtl/ecd_pkg.sv
package ecd_pkg;
    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_SEARCH  = 2'd1,
        ST_QUALIFY = 2'd2,
        ST_LOCKED  = 2'd3
    } ecd_state_t;
endpackage

// File: rtl/ecd_window.sv
module ecd_window #(
    parameter int WORD_W = 10,
    localparam int SLOT_W = WORD_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic              fill_ok,
    output logic              frame_ok,
    output logic [WORD_W-1:0] payload
);
    localparam int FILL_W = $clog2(SLOT_W);
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(SLOT_W - 1);

    logic [SLOT_W-2:0] hist_q;
    logic [SLOT_W-1:0] win;
    logic [FILL_W-1:0] fill_q;

    // window as it stands once this cycle's bit is included
    assign win      = {hist_q, bit_in};
    assign frame_ok = win[SLOT_W-1] & ~win[0];
    assign fill_ok  = (fill_q == FILL_MAX);

    // first payload bit on the line lands in bit 0
    for (genvar i = 0; i < WORD_W; i++) begin : g_pay
        assign payload[i] = win[SLOT_W-2-i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
            fill_q <= '0;
        end else if (clr) begin
            hist_q <= '0;
            fill_q <= '0;
        end else if (bit_vld) begin
            hist_q <= win[SLOT_W-2:0];
            if (!fill_ok) fill_q <= fill_q + 1'b1;
        end
    end
endmodule

// File: rtl/ecd_phase.sv
module ecd_phase #(
    parameter int WORD_W = 10,
    localparam int SLOT_W = WORD_W + 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic restart,
    output logic slot_end,
    output logic clk_hi
);
    localparam int PH_W = $clog2(SLOT_W);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_W - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(SLOT_W / 2);

    logic [PH_W-1:0] phase_q;

    assign slot_end = bit_vld & (phase_q == PH_LAST);
    assign clk_hi   = (phase_q < PH_HALF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      phase_q <= '0;
        else if (bit_vld && restart)     phase_q <= '0;
        else if (bit_vld && slot_end)    phase_q <= '0;
        else if (bit_vld)                phase_q <= phase_q + 1'b1;
    end

    // R11
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(phase_q));

    // R1
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= PH_LAST);
endmodule

// File: rtl/ecd_lock_fsm.sv
module ecd_lock_fsm
    import ecd_pkg::*;
#(
    parameter int QUAL_WORDS = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on,
    input  logic bit_vld,
    input  logic fill_ok,
    input  logic frame_ok,
    input  logic slot_end,
    output logic restart,
    output logic deliver,
    output logic locked,
    output logic suspect_q
);
    localparam int CNT_W = $clog2(QUAL_WORDS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUAL_WORDS - 1);

    ecd_state_t       state_q, state_d;
    logic [CNT_W-1:0] qual_q;
    logic             miss_q;
    logic             lost_q;
    logic             detect, qual_done, loss;

    assign detect    = (state_q == ST_SEARCH) && bit_vld && fill_ok && frame_ok;
    assign qual_done = (state_q == ST_QUALIFY) && slot_end && frame_ok && (qual_q == CNT_LAST);
    assign loss      = (state_q == ST_LOCKED) && slot_end && !frame_ok && miss_q;
    assign locked    = (state_q == ST_LOCKED);

    always_comb begin
        state_d = state_q;
        restart = 1'b0;
        deliver = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                state_d = ST_SEARCH;
            end
            ST_SEARCH: begin
                if (detect) begin
                    state_d = ST_QUALIFY;
                    restart = 1'b1;
                end
            end
            ST_QUALIFY: begin
                if (slot_end && !frame_ok) begin
                    state_d = ST_SEARCH;
                end else if (qual_done) begin
                    state_d = ST_LOCKED;
                    deliver = 1'b1;
                end
            end
            ST_LOCKED: begin
                if (slot_end && frame_ok) deliver = 1'b1;
                else if (loss)            state_d = ST_SEARCH;
            end
            default: state_d = ST_OFF;
        endcase
        if (!pwr_on) begin
            state_d = ST_OFF;
            restart = 1'b0;
            deliver = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qual_q    <= '0;
            miss_q    <= 1'b0;
            lost_q    <= 1'b0;
            suspect_q <= 1'b0;
        end else if (!pwr_on) begin
            qual_q    <= '0;
            miss_q    <= 1'b0;
            lost_q    <= 1'b0;
            suspect_q <= 1'b0;
        end else begin
            if (detect)
                qual_q <= CNT_W'(1);
            else if (state_q == ST_QUALIFY && slot_end && frame_ok && !qual_done)
                qual_q <= qual_q + 1'b1;

            if (state_q == ST_LOCKED && slot_end)
                miss_q <= !frame_ok && !miss_q;
            else if (state_q != ST_LOCKED)
                miss_q <= 1'b0;

            if (loss)           lost_q <= 1'b1;
            else if (qual_done) lost_q <= 1'b0;

            if (qual_done)      suspect_q <= lost_q;
            else if (deliver)   suspect_q <= 1'b0;
            else if (loss)      suspect_q <= 1'b0;
        end
    end

    // R2
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(slot_end && frame_ok));

    // R5
    lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> ($past(!pwr_on) || $past(slot_end && !frame_ok)));

    // R7
    pd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> (state_q == ST_OFF) && !suspect_q);

    // R3
    qual_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qual_q <= CNT_LAST);
endmodule

// File: rtl/ecframe_deser.sv
module ecframe_deser #(
    parameter int WORD_W     = 10,
    parameter int QUAL_WORDS = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on,
    input  logic              out_en,
    input  logic              fall_sel,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word_out,
    output logic              word_stb,
    output logic              drv_en,
    output logic              rclk,
    output logic              lock_n,
    output logic              suspect
);
    logic              fill_ok, frame_ok, slot_end, clk_hi;
    logic              restart, deliver, locked, suspect_q;
    logic [WORD_W-1:0] payload;
    logic [WORD_W-1:0] word_q;
    logic              stb_q;

    ecd_window #(.WORD_W(WORD_W)) i_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!pwr_on),
        .bit_vld  (bit_vld),
        .bit_in   (bit_in),
        .fill_ok  (fill_ok),
        .frame_ok (frame_ok),
        .payload  (payload)
    );

    ecd_phase #(.WORD_W(WORD_W)) i_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_vld  (bit_vld),
        .restart  (restart),
        .slot_end (slot_end),
        .clk_hi   (clk_hi)
    );

    ecd_lock_fsm #(.QUAL_WORDS(QUAL_WORDS)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_on    (pwr_on),
        .bit_vld   (bit_vld),
        .fill_ok   (fill_ok),
        .frame_ok  (frame_ok),
        .slot_end  (slot_end),
        .restart   (restart),
        .deliver   (deliver),
        .locked    (locked),
        .suspect_q (suspect_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            stb_q  <= 1'b0;
        end else if (!pwr_on) begin
            word_q <= '0;
            stb_q  <= 1'b0;
        end else begin
            stb_q <= deliver;
            if (deliver) word_q <= payload;
        end
    end

    assign lock_n   = !(locked && pwr_on);
    assign drv_en   = locked && pwr_on && out_en;
    assign word_out = drv_en ? word_q : '0;
    assign word_stb = stb_q && drv_en;
    assign rclk     = drv_en && (clk_hi ^ fall_sel);
    assign suspect  = suspect_q && drv_en;

    // R8
    stb_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |-> (drv_en && !lock_n));

    // R6
    unlocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_n |-> (!drv_en && !word_stb && !rclk && !suspect));

    // R7
    pd_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |-> (lock_n && !drv_en));
endmodule

// File: tb/test_ecframe_deser.sv
module test_ecframe_deser;
    localparam int CLK_PERIOD = 10;
    localparam int WW = 10;
    localparam int QW = 80;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_on = 1'b1;
    logic          out_en = 1'b1;
    logic          fall_sel = 1'b0;
    logic          bit_vld = 1'b0;
    logic          bit_in = 1'b0;
    logic [WW-1:0] word_out;
    logic          word_stb, drv_en, rclk, lock_n, suspect;

    int checks = 0;
    int errors = 0;
    logic [WW-1:0] last_pl;
    logic [WW-1:0] held;
    bit            mid_clk_chk = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecframe_deser #(.WORD_W(WW), .QUAL_WORDS(QW)) i_ecframe_deser (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .out_en(out_en),
        .fall_sel(fall_sel), .bit_vld(bit_vld), .bit_in(bit_in),
        .word_out(word_out), .word_stb(word_stb), .drv_en(drv_en),
        .rclk(rclk), .lock_n(lock_n), .suspect(suspect)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // expected recovered-clock level a given number of bits after delivery (R9)
    function automatic logic exp_rclk(input int bits_after, input logic fs);
        return ((bits_after % (WW + 2)) < ((WW + 2) / 2)) ^ fs;
    endfunction

    // one line bit, with a random idle gap of bit_vld low cycles (R11)
    task automatic drive_bit(input logic b);
        int gap = (($urandom % 4) == 0) ? int'($urandom % 3) : 0;
        for (int g = 0; g < gap; g++) begin
            bit_vld = 1'b0;
            bit_in  = ~b;
            @(negedge clk);
        end
        bit_vld = 1'b1;
        bit_in  = b;
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic send_slot(input logic st, input logic [WW-1:0] pl, input logic sp);
        drive_bit(st);
        for (int i = 0; i < WW; i++) begin
            drive_bit(pl[i]);
            if (mid_clk_chk && i == 4)
                chk("R9 rclk half slot", rclk, exp_rclk(6, fall_sel));
        end
        drive_bit(sp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive_bit(1'b0);
    endtask

    // idle zeros, an all-zero aligning slot, then QW-1 random slots; bad_at < 0 = all framed
    task automatic acquire(input int bad_at);
        logic [WW-1:0] pl;
        idle(40);
        for (int s = 0; s < QW; s++) begin
            pl = (s == 0) ? '0 : WW'($urandom);
            send_slot(1'b1, pl, (s == bad_at) ? 1'b1 : 1'b0);
            if (s == QW - 2 && bad_at < 0) begin
                chk("R2 no lock before last slot", lock_n, 1'b1);
                chk("R6 drv_en while unlocked", drv_en, 1'b0);
                chk("R6 rclk while unlocked", rclk, 1'b0);
                chk("R6 word_stb while unlocked", word_stb, 1'b0);
            end
        end
        last_pl = pl;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [WW-1:0] pl;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 lock_n", lock_n, 1'b1);
        chk("R12 drv_en", drv_en, 1'b0);
        chk("R12 word_stb", word_stb, 1'b0);
        chk("R12 rclk", rclk, 1'b0);
        chk("R12 suspect", suspect, 1'b0);
        chk("R12 word_out", 32'(word_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 qualification broken at slot 40: no lock
        acquire(40);
        chk("R3 no lock after broken run", lock_n, 1'b1);

        // R2 clean acquisition
        acquire(-1);
        chk("R2 lock_n low on last slot", lock_n, 1'b0);
        chk("R2 word_stb with lock", word_stb, 1'b1);
        chk("R1 first word payload", 32'(word_out), 32'(last_pl));
        chk("R10 first lock not suspect", suspect, 1'b0);
        chk("R9 rclk at delivery rise", rclk, exp_rclk(0, 1'b0));

        // R1 / R11 random words with gaps
        for (int k = 0; k < 12; k++) begin
            pl = WW'($urandom);
            send_slot(1'b1, pl, 1'b0);
            chk("R1 locked word", 32'(word_out), 32'(pl));
            chk("R1 strobe", word_stb, 1'b1);
        end

        // R9 falling-edge alignment and half-slot level
        fall_sel = 1'b1;
        mid_clk_chk = 1;
        pl = WW'($urandom);
        send_slot(1'b1, pl, 1'b0);
        chk("R9 rclk at delivery fall", rclk, exp_rclk(0, 1'b1));
        send_slot(1'b1, WW'($urandom), 1'b0);
        fall_sel = 1'b0;
        pl = WW'($urandom);
        send_slot(1'b1, pl, 1'b0);
        chk("R9 rclk at delivery rise", rclk, exp_rclk(0, 1'b0));
        mid_clk_chk = 0;

        // R4 single miss
        held = word_out;
        send_slot(1'b0, WW'($urandom), 1'b0);
        chk("R4 still locked", lock_n, 1'b0);
        chk("R4 no strobe", word_stb, 1'b0);
        chk("R4 word held", 32'(word_out), 32'(held));
        pl = WW'($urandom);
        send_slot(1'b1, pl, 1'b0);
        chk("R4 resume word", 32'(word_out), 32'(pl));

        // R8 output enable
        out_en = 1'b0;
        send_slot(1'b1, WW'($urandom), 1'b0);
        chk("R8 drv_en off", drv_en, 1'b0);
        chk("R8 no strobe", word_stb, 1'b0);
        chk("R8 rclk off", rclk, 1'b0);
        chk("R8 lock kept", lock_n, 1'b0);
        out_en = 1'b1;
        pl = WW'($urandom);
        send_slot(1'b1, pl, 1'b0);
        chk("R8 resume strobe", word_stb, 1'b1);
        chk("R8 resume word", 32'(word_out), 32'(pl));

        // R5 two misses then automatic relock, R10 suspect
        send_slot(1'b1, WW'($urandom), 1'b1);
        chk("R5 one miss still locked", lock_n, 1'b0);
        send_slot(1'b1, WW'($urandom), 1'b1);
        chk("R5 lock lost", lock_n, 1'b1);
        chk("R5 drive off", drv_en, 1'b0);
        acquire(-1);
        chk("R5 relocked", lock_n, 1'b0);
        chk("R10 suspect on relock", suspect, 1'b1);
        chk("R1 relock word", 32'(word_out), 32'(last_pl));
        pl = WW'($urandom);
        send_slot(1'b1, pl, 1'b0);
        chk("R10 suspect cleared", suspect, 1'b0);

        // R7 power-down
        pwr_on = 1'b0;
        #1;
        chk("R7 lock_n in power-down", lock_n, 1'b1);
        chk("R7 drv_en in power-down", drv_en, 1'b0);
        repeat (3) @(negedge clk);
        pwr_on = 1'b1;
        send_slot(1'b1, '0, 1'b0);
        send_slot(1'b1, WW'($urandom), 1'b0);
        chk("R7 no lock without requalify", lock_n, 1'b1);
        acquire(-1);
        chk("R7 lock after power-up", lock_n, 1'b0);
        chk("R10 not suspect after power-up", suspect, 1'b0);
        chk("R1 power-up word", 32'(word_out), 32'(last_pl));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule